// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block manages a pair of 8-bit ports: a bidirectional port whose lines are driven through output and enable vectors, and an output-only port. A single strobe input from a peer and a single strobe output to it carry five protocols. Two are simple: a timed pulse on every write to the output-only port, and a capture of the bidirectional pins on every active input strobe edge. Three are full handshakes on the bidirectional port: a ready/acknowledge input exchange, a data-ready/acknowledge output exchange, and an output exchange in which the port is driven only while the peer holds its strobe active.

The CPU uses a small register window with five addresses: the port data register, a capture/transmit latch, a direction register, a control register and the output-only port register. The strobe input passes through a synchronizer before edge detection. A status flag records active edges and can raise an interrupt.

Top module: `pio_handshake`

## Requirements
- R1: After reset, `strobe_out` is 0, `pc_oe` is 0x00, `irq` is 0 and the control register (address 3) reads 0x00.
- R2: With control mode field bits[2:0] = 1 (simple pulse output), a write to address 4 updates `pb_out` and holds the strobe active for exactly 2 clock cycles starting with the cycle after the write. In mode 0, a write to address 4 produces no pulse.
- R3: Control bit 4 inverts the strobe output. `strobe_out` equals the internal active state XOR bit 4, so the idle level becomes 1.
- R4: Control bit 3 selects the active strobe edge and level (1 = rising/high, 0 = falling/low). In mode 0 (simple capture), each active edge copies `pc_pins` into the latch (address 1) and sets the flag (control bit 7), with the result visible by the third clock edge after the pin change. An inactive edge changes neither the latch nor the flag.
- R5: Outside mode 4, `pc_oe` equals the direction register (address 2, 1 = output). Outside modes 3 and 4, `pc_out` equals the port data register. A read of address 0 returns the register bit on output lines and the pin level on input lines.
- R6: In mode 2 (input handshake), writing the control register makes the strobe active (ready). An active edge captures the pins and makes it inactive. It becomes active again only after a read of address 1.
- R7: In mode 3 (output handshake), a write to address 1 makes the strobe active and places the latch on `pc_out`. The acknowledging active edge makes the strobe inactive and sets the flag.
- R8: In mode 4 (three-state output), an active edge while the strobe is active enables all eight lines of `pc_oe` and drives the latch, whatever the direction bits. The lines stay enabled while the synchronized strobe input remains at its active level, and fall back to the direction register once it leaves that level.
- R9: The flag is cleared by a read of the control register with the flag set, followed by any access to address 1. An access to address 1 without that preceding read leaves the flag set.
- R10: `irq` is high only when the flag and the interrupt enable (control bit 5) are both set.
- R11: Control bit 7 is read-only. Writing 1 to it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register select (0 port, 1 latch, 2 direction, 3 control, 4 output-only port) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| strobe_in | input | 1 | Asynchronous peer strobe |
| strobe_out | output | 1 | Strobe / ready output |
| pc_pins | input | 8 | Bidirectional port pin levels |
| pc_out | output | 8 | Bidirectional port drive values |
| pc_oe | output | 8 | Bidirectional port drive enables |
| pb_out | output | 8 | Output-only port |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the three-state drive window. The bench must select mode 4 with all direction bits cleared, write the latch so that data-ready is active, and then raise the peer strobe and hold it past the synchronizer delay. Only then do the enables override the direction register. The bench samples the enables while the strobe is held, and again after it is released three edges later. The flag clear sequence is also reached only by a particular order of accesses. The bench exercises both the arming read and a latch access without that read, and random capture rounds repeat the full order.

// File: rtl/pio_pkg.sv
// Package: shared mode encoding, register addresses and control bit positions
// for the parallel port handshake controller. Assumes an 8-bit register window.
package pio_pkg;

    typedef enum logic [2:0] {
        MODE_SIN  = 3'd0,   // simple strobed capture
        MODE_SOUT = 3'd1,   // simple pulse on output-only port write
        MODE_FIN  = 3'd2,   // full input handshake
        MODE_FOUT = 3'd3,   // full output handshake
        MODE_TRI  = 3'd4    // output handshake, driven only during acknowledge
    } pio_mode_e;

    localparam logic [2:0] ADDR_PORT = 3'd0;
    localparam logic [2:0] ADDR_ALT  = 3'd1;
    localparam logic [2:0] ADDR_DDR  = 3'd2;
    localparam logic [2:0] ADDR_CTRL = 3'd3;
    localparam logic [2:0] ADDR_OUT  = 3'd4;

    localparam int CTL_EDGE = 3;
    localparam int CTL_INV  = 4;
    localparam int CTL_IE   = 5;
    localparam int CTL_FLAG = 7;

    // Map a raw mode field to a mode; unused codes fall back to simple capture.
    function automatic pio_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return MODE_SOUT;
            3'd2:    return MODE_FIN;
            3'd3:    return MODE_FOUT;
            3'd4:    return MODE_TRI;
            default: return MODE_SIN;
        endcase
    endfunction

endpackage

// File: rtl/pio_strobe_sync.sv
// Module: pio_strobe_sync
// Brings the asynchronous strobe input into the clock domain through a chain
// of STAGES flops, then detects edges against one further history flop.
// Assumes STAGES >= 2. Outputs an edge pulse for the selected polarity and a
// level flag that is true while the synchronized input sits at the active level.
module pio_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic active_high,
    output logic edge_evt,
    output logic level_act
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = chain_q[STAGES-1];

    // History flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    // Edge and level decode for the selected polarity.
    always_comb begin
        if (active_high) edge_evt = synced & ~prev_q;
        else             edge_evt = ~synced & prev_q;
        level_act = (synced == active_high);
    end
endmodule

// File: rtl/pio_strobe_ctrl.sv
// Module: pio_strobe_ctrl
// Holds the protocol state: pulse counter, handshake state, three-state drive
// window, status flag and its clear arming. Assumes register access strobes are
// single-cycle and already decoded. A control write restarts the protocol state.
module pio_strobe_ctrl
    import pio_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pio_mode_e mode,
    input  pio_mode_e new_mode,
    input  logic      inv,
    input  logic      ctrl_wr,
    input  logic      ctrl_rd,
    input  logic      out_wr,
    input  logic      alt_wr,
    input  logic      alt_rd,
    input  logic      alt_acc,
    input  logic      edge_evt,
    input  logic      level_act,
    output logic      strobe_out,
    output logic      capture,
    output logic      flag_q,
    output logic      hs_q,
    output logic      drive_q
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_q;
    logic          arm_q;
    logic          act;

    // Pulse length counter for the simple output mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (ctrl_wr)                     cnt_q <= '0;
        else if (out_wr && mode == MODE_SOUT) cnt_q <= CW'(PULSE_LEN);
        else if (cnt_q != '0)                 cnt_q <= cnt_q - CW'(1);
    end

    // Handshake state: ready in input handshake, data-ready in output handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
        end else if (ctrl_wr) begin
            hs_q <= (new_mode == MODE_FIN);
        end else begin
            case (mode)
                MODE_FIN: begin
                    if (edge_evt)    hs_q <= 1'b0;
                    else if (alt_rd) hs_q <= 1'b1;
                end
                MODE_FOUT, MODE_TRI: begin
                    if (alt_wr)      hs_q <= 1'b1;
                    else if (edge_evt) hs_q <= 1'b0;
                end
                default: hs_q <= 1'b0;
            endcase
        end
    end

    // Three-state drive window: opens on acknowledge, closes when strobe leaves active level.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr)           drive_q <= 1'b0;
        else if (mode != MODE_TRI)       drive_q <= 1'b0;
        else if (edge_evt && hs_q)       drive_q <= 1'b1;
        else if (!level_act)             drive_q <= 1'b0;
    end

    // Status flag: set by any active edge, cleared by an armed latch access.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (edge_evt)         flag_q <= 1'b1;
        else if (arm_q && alt_acc) flag_q <= 1'b0;
    end

    // Clear arming: a control read with the flag set arms; a latch access disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                arm_q <= 1'b0;
        else if (alt_acc)          arm_q <= 1'b0;
        else if (ctrl_rd && flag_q) arm_q <= 1'b1;
    end

    // Mode-dependent active strobe state and capture enable.
    always_comb begin
        case (mode)
            MODE_SOUT:                    act = (cnt_q != '0);
            MODE_FIN, MODE_FOUT, MODE_TRI: act = hs_q;
            default:                      act = 1'b0;
        endcase
        strobe_out = act ^ inv;
        capture    = edge_evt && (mode == MODE_SIN || mode == MODE_FIN);
    end
endmodule

// File: rtl/pio_regs.sv
// Module: pio_regs
// CPU register window: address decode, port/latch/direction/control/output
// registers, read mux and the bidirectional pin drive. Assumes one access per
// cycle and that rdata is consumed in the cycle it is presented.
module pio_regs
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pins,
    input  logic          capture,
    input  logic          flag,
    input  logic          drive,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] ddr_q,
    output pio_mode_e     mode,
    output pio_mode_e     new_mode,
    output logic          edge_hi,
    output logic          inv,
    output logic          ie,
    output logic          ctrl_wr,
    output logic          ctrl_rd,
    output logic          out_wr,
    output logic          alt_wr,
    output logic          alt_rd,
    output logic          alt_acc
);
    logic [DW-1:0] port_q;
    logic [DW-1:0] alt_q;
    logic [DW-1:0] outp_q;
    logic [2:0]    mode_raw_q;
    logic          port_wr;
    logic          ddr_wr;

    // Access decode.
    always_comb begin
        port_wr  = wr_en && addr == ADDR_PORT;
        alt_wr   = wr_en && addr == ADDR_ALT;
        ddr_wr   = wr_en && addr == ADDR_DDR;
        ctrl_wr  = wr_en && addr == ADDR_CTRL;
        out_wr   = wr_en && addr == ADDR_OUT;
        alt_rd   = rd_en && addr == ADDR_ALT;
        ctrl_rd  = rd_en && addr == ADDR_CTRL;
        alt_acc  = alt_wr || alt_rd;
        new_mode = decode_mode(wdata[2:0]);
        mode     = decode_mode(mode_raw_q);
    end

    // Port data and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            ddr_q  <= '0;
            outp_q <= '0;
        end else begin
            if (port_wr) port_q <= wdata;
            if (ddr_wr)  ddr_q  <= wdata;
            if (out_wr)  outp_q <= wdata;
        end
    end

    // Latch: pin capture takes priority over a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)       alt_q <= '0;
        else if (capture) alt_q <= pins;
        else if (alt_wr)  alt_q <= wdata;
    end

    // Control fields; the flag position is not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_raw_q <= 3'd0;
            edge_hi    <= 1'b0;
            inv        <= 1'b0;
            ie         <= 1'b0;
        end else if (ctrl_wr) begin
            mode_raw_q <= wdata[2:0];
            edge_hi    <= wdata[CTL_EDGE];
            inv        <= wdata[CTL_INV];
            ie         <= wdata[CTL_IE];
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_PORT: rdata = (ddr_q & port_q) | (~ddr_q & pins);
            ADDR_ALT:  rdata = alt_q;
            ADDR_DDR:  rdata = ddr_q;
            ADDR_CTRL: begin
                rdata[2:0]      = mode_raw_q;
                rdata[CTL_EDGE] = edge_hi;
                rdata[CTL_INV]  = inv;
                rdata[CTL_IE]   = ie;
                rdata[CTL_FLAG] = flag;
            end
            ADDR_OUT:  rdata = outp_q;
            default:   rdata = '0;
        endcase
    end

    // Pin drive: output handshakes present the latch; the drive window enables all lines.
    always_comb begin
        pc_out = (mode == MODE_FOUT || mode == MODE_TRI) ? alt_q : port_q;
        pc_oe  = drive ? '1 : ddr_q;
        pb_out = outp_q;
    end
endmodule

// File: rtl/pio_handshake.sv
// Module: pio_handshake (top)
// Parallel port handshake controller: ties the strobe synchronizer, protocol
// state and register window together. Assumes strobe_in is asynchronous and
// all other inputs are synchronous to clk.
module pio_handshake
    import pio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              strobe_in,
    output logic              strobe_out,
    input  logic [DATA_W-1:0] pc_pins,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic              irq
);
    pio_mode_e         mode;
    pio_mode_e         new_mode;
    logic [DATA_W-1:0] ddr_q;
    logic edge_hi, inv, ie;
    logic ctrl_wr, ctrl_rd, out_wr, alt_wr, alt_rd, alt_acc;
    logic edge_evt, level_act, capture, flag_q, hs_q, drive_q;

    pio_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(strobe_in), .active_high(edge_hi),
        .edge_evt(edge_evt), .level_act(level_act)
    );

    pio_strobe_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .new_mode(new_mode), .inv(inv),
        .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .out_wr(out_wr), .alt_wr(alt_wr),
        .alt_rd(alt_rd), .alt_acc(alt_acc), .edge_evt(edge_evt),
        .level_act(level_act), .strobe_out(strobe_out), .capture(capture),
        .flag_q(flag_q), .hs_q(hs_q), .drive_q(drive_q)
    );

    pio_regs #(.DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pins(pc_pins), .capture(capture),
        .flag(flag_q), .drive(drive_q), .pc_out(pc_out), .pc_oe(pc_oe),
        .pb_out(pb_out), .ddr_q(ddr_q), .mode(mode), .new_mode(new_mode),
        .edge_hi(edge_hi), .inv(inv), .ie(ie), .ctrl_wr(ctrl_wr),
        .ctrl_rd(ctrl_rd), .out_wr(out_wr), .alt_wr(alt_wr), .alt_rd(alt_rd),
        .alt_acc(alt_acc)
    );

    // Interrupt request gating.
    assign irq = flag_q & ie;
endmodule

// File: rtl/pio_handshake_checker.sv
// Module: pio_handshake_checker
// Protocol assertions for pio_handshake, attached by bind below.
module pio_handshake_checker
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input pio_mode_e     mode,
    input logic          inv,
    input logic          ie,
    input logic          ctrl_wr,
    input logic [DW-1:0] ddr_q,
    input logic [DW-1:0] pc_oe,
    input logic          strobe_out,
    input logic          irq,
    input logic          edge_evt,
    input logic          level_act,
    input logic          flag_q,
    input logic          hs_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_oe == '0 && irq == 1'b0));

    assert_pulse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOUT && !ctrl_wr && $stable(inv) && $stable(mode) &&
         $rose(strobe_out ^ inv)) |=> (strobe_out ^ inv));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> flag_q);

    assert_oe_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TRI) |-> (pc_oe == ddr_q));

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIN && edge_evt && !ctrl_wr) |=> !hs_q);

    assert_tri_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRI && pc_oe != ddr_q) |-> $past(level_act));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && ie));
endmodule

bind pio_handshake pio_handshake_checker #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .inv(inv), .ie(ie),
    .ctrl_wr(ctrl_wr), .ddr_q(ddr_q), .pc_oe(pc_oe), .strobe_out(strobe_out),
    .irq(irq), .edge_evt(edge_evt), .level_act(level_act), .flag_q(flag_q),
    .hs_q(hs_q)
);

// File: tb/pio_handshake_bench.sv
`timescale 1ns/1ps
module pio_handshake_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       strobe_in = 1'b0;
    logic       strobe_out;
    logic [7:0] pc_pins = '0;
    logic [7:0] pc_out, pc_oe, pb_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_handshake u_pio_handshake (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .strobe_in(strobe_in),
        .strobe_out(strobe_out), .pc_pins(pc_pins), .pc_out(pc_out),
        .pc_oe(pc_oe), .pb_out(pb_out), .irq(irq)
    );

    function automatic logic [7:0] exp_port(input logic [7:0] d, input logic [7:0] p,
                                            input logic [7:0] n);
        return (d & p) | (~d & n);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic stra(input logic v);
        @(negedge clk); strobe_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Sample strobe for three cycles after a write: active, active, idle.
    task automatic pulse_chk(input string req, input logic idle);
        chk(req, {7'd0, strobe_out}, {7'd0, ~idle});
        @(negedge clk); chk(req, {7'd0, strobe_out}, {7'd0, ~idle});
        @(negedge clk); chk(req, {7'd0, strobe_out}, {7'd0, idle});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d, p, n;
        int unsigned s;
        s = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobe", {7'd0, strobe_out}, 8'h00);
        chk("R1 oe", pc_oe, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd3, v); chk("R1 ctrl", v, 8'h00);
        // R11 flag bit not writable
        wr(3'd3, 8'h80); rd(3'd3, v); chk("R11 ctrl", v, 8'h00);
        // R5 random GPIO
        wr(3'd3, 8'h00);
        for (int i = 0; i < 16; i++) begin
            d = 8'($urandom); p = 8'($urandom); n = 8'($urandom);
            wr(3'd2, d); wr(3'd0, p); pc_pins = n;
            rd(3'd0, v);
            chk("R5 read", v, exp_port(d, p, n));
            chk("R5 oe", pc_oe, d);
            chk("R5 out", pc_out, p);
        end
        wr(3'd2, 8'h00);
        // R4 simple capture, R9 clear, R10 irq
        wr(3'd3, 8'h28);
        for (int i = 0; i < 8; i++) begin
            p = 8'($urandom); pc_pins = p;
            stra(1'b1);
            chk("R10 irq set", {7'd0, irq}, 8'h01);
            rd(3'd3, v); chk("R4 flag", v, 8'hA8);
            rd(3'd1, v); chk("R4 capture", v, p);
            chk("R9 cleared irq", {7'd0, irq}, 8'h00);
            pc_pins = ~p;
            stra(1'b0);
            rd(3'd1, v); chk("R4 inactive edge latch", v, p);
            rd(3'd3, v); chk("R4 inactive edge flag", v, 8'h28);
        end
        // R9 latch access without arming read keeps flag
        pc_pins = 8'h5A; stra(1'b1);
        rd(3'd1, v);
        rd(3'd3, v); chk("R9 unarmed", v, 8'hA8);
        rd(3'd1, v);
        rd(3'd3, v); chk("R9 armed clear", v, 8'h28);
        stra(1'b0);
        // R10 enable off
        wr(3'd3, 8'h08); stra(1'b1);
        chk("R10 masked", {7'd0, irq}, 8'h00);
        rd(3'd3, v); chk("R10 flag", v, 8'h88);
        rd(3'd1, v); stra(1'b0);
        // R2 pulse, R3 invert
        wr(3'd3, 8'h01);
        chk("R2 idle", {7'd0, strobe_out}, 8'h00);
        wr(3'd4, 8'hC3);
        chk("R2 pb", pb_out, 8'hC3);
        pulse_chk("R2 pulse", 1'b0);
        wr(3'd3, 8'h11);
        chk("R3 idle", {7'd0, strobe_out}, 8'h01);
        wr(3'd4, 8'h3C);
        pulse_chk("R3 pulse", 1'b1);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h99);
        chk("R2 mode0 pb", pb_out, 8'h99);
        for (int i = 0; i < 3; i++) begin
            chk("R2 no pulse", {7'd0, strobe_out}, 8'h00);
            @(negedge clk);
        end
        // R6 input handshake
        wr(3'd3, 8'h0A);
        chk("R6 ready", {7'd0, strobe_out}, 8'h01);
        pc_pins = 8'hA5; stra(1'b1);
        chk("R6 not ready", {7'd0, strobe_out}, 8'h00);
        stra(1'b0);
        chk("R6 still not ready", {7'd0, strobe_out}, 8'h00);
        rd(3'd1, v); chk("R6 latch", v, 8'hA5);
        chk("R6 reready", {7'd0, strobe_out}, 8'h01);
        // R7 output handshake
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h0B);
        chk("R7 idle", {7'd0, strobe_out}, 8'h00);
        wr(3'd1, 8'h6E);
        chk("R7 ready", {7'd0, strobe_out}, 8'h01);
        chk("R7 out", pc_out, 8'h6E);
        stra(1'b1);
        chk("R7 ack", {7'd0, strobe_out}, 8'h00);
        rd(3'd3, v); chk("R7 flag", v, 8'h8B);
        rd(3'd1, v); stra(1'b0);
        // R8 three-state
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h0C);
        wr(3'd1, 8'h47);
        chk("R8 ready", {7'd0, strobe_out}, 8'h01);
        chk("R8 oe before", pc_oe, 8'h00);
        stra(1'b1);
        chk("R8 oe drive", pc_oe, 8'hFF);
        chk("R8 out", pc_out, 8'h47);
        chk("R8 ack", {7'd0, strobe_out}, 8'h00);
        repeat (2) @(negedge clk);
        chk("R8 oe held", pc_oe, 8'hFF);
        stra(1'b0);
        chk("R8 oe release", pc_oe, 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule